// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block sends characters on an asynchronous serial line. Software writes a byte into a one-deep holding buffer. If the transmitter is enabled and its shift register is idle, the byte moves into the shift register on the next clock. It then goes out as a start bit, 5 to 9 data bits (LSB first), an optional even or odd parity bit, and one or two stop bits. The buffer is free again as soon as its byte has moved on. Software can therefore queue the next character while the current one is still shifting out.

A 12-bit divisor sets the bit rate. A prescaler produces one tick every divisor+1 clocks, and a bit lasts 16 ticks, or 8 ticks in double-speed mode. The ninth data bit sits in the control register and is latched together with the byte write. Two flags report progress:
- buffer-empty shows when the holding buffer can take a new byte;
- transmit-complete shows that the line has drained.

Each flag drives an interrupt that is gated by its own enable and by a global enable. Clearing the enable does not cut a transfer short. The line stays driven until every queued character has been sent.

The sequencer has six states:
- `ST_IDLE`: waiting for a character to send.
- `ST_START`: sending the start bit.
- `ST_DATA`: sending the data bits.
- `ST_PARITY`: sending the parity bit.
- `ST_STOP1`: sending the first stop bit.
- `ST_STOP2`: sending the second stop bit.

It moves between them as follows:
- `ST_IDLE`→`ST_START` when a buffered character is taken while the line is driven.
- `ST_START`→`ST_DATA` at the end of the start bit.
- `ST_DATA`→`ST_DATA` after each data bit except the last.
- `ST_DATA`→`ST_PARITY` after the last data bit, if parity is on.
- `ST_DATA`→`ST_STOP1` after the last data bit, if parity is off.
- `ST_PARITY`→`ST_STOP1` at the end of the parity bit.
- `ST_STOP1`→`ST_STOP2` if two stop bits are selected.
- `ST_STOP1`→`ST_IDLE` if one stop bit is selected.
- `ST_STOP2`→`ST_IDLE` at the end of the second stop bit.

Top module: `dbuf_uart_tx`

## Requirements
- R1: A write to address 0 (data) is accepted only while the buffer-empty flag is 1. Otherwise it is ignored: the held character and the characters later sent are unchanged.
- R2: After reset the outputs are as follows:
  - buffer-empty is 1;
  - transmit-complete is 0;
  - `txd` is 1;
  - `line_active` is 0;
  - both interrupts are 0.
- R3: With the line driven, the sequencer idle and the buffer full, the character moves into the shift register on the next clock. In the same cycle buffer-empty returns to 1 and `txd` goes low for the start bit.
- R4: The frame on the line is made up of:
  - a 0 start bit;
  - N data bits, LSB first, with bit 8 taken from control bit 1. N is set by the frame register bits [2:0]: 0→5, 1→6, 2→7, 7→9, any other value→8;
  - a parity bit when frame bits [4:3] are 2 (even) or 3 (odd); none for any other value;
  - stop bits at 1.
  Data bits above N are dropped.
- R5: Every bit lasts (divisor+1)×16 clocks, or (divisor+1)×8 clocks when frame bit 6 is set. The divisor low byte is at address 3 and the high nibble at address 4. Writing the low byte reloads the prescaler at once.
- R6: Frame bit 5 selects the number of stop bits: 0 gives one stop bit, 1 gives two.
- R7: Transmit-complete behaves as follows:
  - It sets when the last stop bit of a frame ends with the buffer empty.
  - It stays 0 if a character is waiting at that moment.
  - Writing 1 to bit 0 of address 5 clears it; writing 0 there does not.
  - A pulse on `txc_ack` also clears it.
- R8: Clearing control bit 0 (enable) takes effect only once the buffer and the shift register are both empty. `line_active` then drops to 0 and `txd` rests at 1. A character written while the line is released is held until the transmitter is enabled again.
- R9: The ninth data bit is captured at the data write. A later change to control bit 1 does not alter a character that has already been accepted.
- R10: `dre_irq` is control bit 2 AND `irq_global_en` AND buffer-empty. `txc_irq` is control bit 3 AND `irq_global_en` AND transmit-complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address (0 data, 1 control, 2 frame, 3 divisor low, 4 divisor high, 5 flags) |
| bus_wdata | input | 8 | Write data |
| txc_ack | input | 1 | Transmit-complete interrupt acknowledge |
| irq_global_en | input | 1 | Global interrupt enable |
| txd | output | 1 | Serial line |
| line_active | output | 1 | Transmitter is driving the line |
| dre_flag | output | 1 | Holding buffer empty |
| txc_flag | output | 1 | Transmit complete |
| dre_irq | output | 1 | Buffer-empty interrupt |
| txc_irq | output | 1 | Transmit-complete interrupt |

## Verification
The line is decoded by a bench-side receiver that samples mid-bit. It is run with the following inputs:
- 5-bit with even parity and two stop bits;
- 7-bit with odd parity;
- 9-bit with no parity;
- 8-bit with one or two stop bits.

Together these separate data ordering, masking, parity sense and stop count. The start-bit length is measured directly at two divisor and speed settings, which isolates the prescaler from the framing. The whole-frame length is measured to transmit-complete, which pins down where the frame ends.

Back-to-back writes are issued while the buffer is occupied. These expose whether an extra write is dropped correctly and whether transmit-complete is suppressed while a character is waiting. A disable issued with two characters still queued shows whether the release of the line is deferred.

// File: rtl/dbuf_uart_tx_pkg.sv
package dbuf_uart_tx_pkg;

    localparam int ADDR_DATA   = 0;
    localparam int ADDR_CTRL   = 1;
    localparam int ADDR_FRAME  = 2;
    localparam int ADDR_DIV_LO = 3;
    localparam int ADDR_DIV_HI = 4;
    localparam int ADDR_FLAGS  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } tx_state_t;

    typedef struct packed {
        logic       dbl;
        logic       two_stop;
        logic [1:0] par_mode;
        logic [2:0] size_code;
    } frame_cfg_t;

    typedef struct packed {
        logic txc_ie;
        logic dre_ie;
        logic ninth;
        logic en;
    } ctrl_t;

    function automatic logic [3:0] size_to_bits(input logic [2:0] code);
        case (code)
            3'd0:    return 4'd5;
            3'd1:    return 4'd6;
            3'd2:    return 4'd7;
            3'd7:    return 4'd9;
            default: return 4'd8;
        endcase
    endfunction

endpackage

// File: rtl/dbuf_uart_tx_baud.sv
module dbuf_uart_tx_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor,
    input  logic             reload,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload || cnt_q == '0) begin
            cnt_q <= divisor;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = (cnt_q == '0) && !reload;

    a_r5_tick_after_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && divisor != '0) |=> !tick);

endmodule

// File: rtl/dbuf_uart_tx_fsm.sv
module dbuf_uart_tx_fsm
    import dbuf_uart_tx_pkg::*;
#(
    parameter int OSR_NORMAL = 16,
    parameter int OSR_DOUBLE = 8,
    parameter int WORD_W     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              buf_valid,
    input  logic [WORD_W-1:0] buf_word,
    input  frame_cfg_t        cfg,
    input  logic              tick,
    output logic              take,
    output logic              busy,
    output logic              txd_bit,
    output logic              frame_done
);

    localparam int SUB_W = $clog2(OSR_NORMAL);
    localparam int IDX_W = $clog2(WORD_W + 1);

    tx_state_t         state_q, state_d;
    logic [SUB_W-1:0]  sub_q, sub_last;
    logic [IDX_W-1:0]  idx_q, nbits_q, nbits_new;
    logic [WORD_W-1:0] shreg_q, word_mask;
    logic              par_en_q, par_bit_q, two_stop_q;
    logic              bit_end, last_data;

    assign sub_last  = cfg.dbl ? SUB_W'(OSR_DOUBLE - 1) : SUB_W'(OSR_NORMAL - 1);
    assign bit_end   = tick && (state_q != ST_IDLE) && (sub_q == sub_last);
    assign last_data = (idx_q == nbits_q - IDX_W'(1));
    assign nbits_new = IDX_W'(size_to_bits(cfg.size_code));
    assign take      = (state_q == ST_IDLE) && run && buf_valid;

    always_comb begin
        for (int i = 0; i < WORD_W; i++) begin
            word_mask[i] = (i < int'(nbits_new));
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (take) state_d = ST_START;
            ST_START:  if (bit_end) state_d = ST_DATA;
            ST_DATA:   if (bit_end && last_data) state_d = par_en_q ? ST_PARITY : ST_STOP1;
            ST_PARITY: if (bit_end) state_d = ST_STOP1;
            ST_STOP1:  if (bit_end) state_d = two_stop_q ? ST_STOP2 : ST_IDLE;
            ST_STOP2:  if (bit_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        txd_bit    = 1'b1;
        frame_done = 1'b0;
        unique case (state_q)
            ST_IDLE:   txd_bit = 1'b1;
            ST_START:  txd_bit = 1'b0;
            ST_DATA:   txd_bit = shreg_q[0];
            ST_PARITY: txd_bit = par_bit_q;
            ST_STOP1:  frame_done = bit_end && !two_stop_q;
            ST_STOP2:  frame_done = bit_end;
            default:   txd_bit = 1'b1;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q      <= '0;
            idx_q      <= '0;
            nbits_q    <= IDX_W'(8);
            shreg_q    <= '0;
            par_en_q   <= 1'b0;
            par_bit_q  <= 1'b0;
            two_stop_q <= 1'b0;
        end else if (take) begin
            sub_q      <= '0;
            idx_q      <= '0;
            nbits_q    <= nbits_new;
            shreg_q    <= buf_word & word_mask;
            par_en_q   <= cfg.par_mode[1];
            par_bit_q  <= (^(buf_word & word_mask)) ^ cfg.par_mode[0];
            two_stop_q <= cfg.two_stop;
        end else if (tick && busy) begin
            sub_q <= bit_end ? '0 : sub_q + 1'b1;
            if (bit_end && state_q == ST_DATA) begin
                shreg_q <= shreg_q >> 1;
                idx_q   <= idx_q + 1'b1;
            end
        end
    end

    a_r6_second_stop_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP2) |-> two_stop_q);
    a_r4_data_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (idx_q < nbits_q));
    a_r3_start_follows_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (state_q == ST_START) && !txd_bit);

endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx
    import dbuf_uart_tx_pkg::*;
#(
    parameter int DIV_W      = 12,
    parameter int ADDR_W     = 3,
    parameter int BUS_W      = 8,
    parameter int OSR_NORMAL = 16,
    parameter int OSR_DOUBLE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              txc_ack,
    input  logic              irq_global_en,
    output logic              txd,
    output logic              line_active,
    output logic              dre_flag,
    output logic              txc_flag,
    output logic              dre_irq,
    output logic              txc_irq
);

    localparam int WORD_W = BUS_W + 1;
    localparam int HI_W   = DIV_W - BUS_W;
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int CFG_W  = $bits(frame_cfg_t);

    ctrl_t             ctrl_q;
    frame_cfg_t        frame_q;
    logic [DIV_W-1:0]  div_q, div_next;
    logic [WORD_W-1:0] buf_q;
    logic              buf_full_q, txc_q, drive_q;
    logic              wr_data, wr_ctrl, wr_frame, wr_lo, wr_hi, wr_flags;
    logic              accept, txc_clear;
    logic              tick, take, busy, txd_bit, frame_done;

    assign wr_data  = bus_wr && bus_addr == ADDR_W'(ADDR_DATA);
    assign wr_ctrl  = bus_wr && bus_addr == ADDR_W'(ADDR_CTRL);
    assign wr_frame = bus_wr && bus_addr == ADDR_W'(ADDR_FRAME);
    assign wr_lo    = bus_wr && bus_addr == ADDR_W'(ADDR_DIV_LO);
    assign wr_hi    = bus_wr && bus_addr == ADDR_W'(ADDR_DIV_HI);
    assign wr_flags = bus_wr && bus_addr == ADDR_W'(ADDR_FLAGS);

    assign accept    = wr_data && !buf_full_q;
    assign txc_clear = txc_ack || (wr_flags && bus_wdata[0]);
    assign div_next  = wr_lo ? {div_q[DIV_W-1:BUS_W], bus_wdata} : div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            frame_q <= '{dbl: 1'b0, two_stop: 1'b0, par_mode: 2'd0, size_code: 3'd3};
            div_q   <= '0;
        end else begin
            if (wr_ctrl)  ctrl_q  <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (wr_frame) frame_q <= frame_cfg_t'(bus_wdata[CFG_W-1:0]);
            if (wr_lo)    div_q   <= div_next;
            if (wr_hi)    div_q[DIV_W-1:BUS_W] <= bus_wdata[HI_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q      <= '0;
            buf_full_q <= 1'b0;
            txc_q      <= 1'b0;
            drive_q    <= 1'b0;
        end else begin
            if (accept) begin
                buf_q      <= {ctrl_q.ninth, bus_wdata};
                buf_full_q <= 1'b1;
            end else if (take) begin
                buf_full_q <= 1'b0;
            end
            if (frame_done && !buf_full_q) begin
                txc_q <= 1'b1;
            end else if (txc_clear) begin
                txc_q <= 1'b0;
            end
            drive_q <= ctrl_q.en || (drive_q && (buf_full_q || busy));
        end
    end

    dbuf_uart_tx_baud #(
        .DIV_W (DIV_W)
    ) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .divisor (div_next),
        .reload  (take || wr_lo),
        .tick    (tick)
    );

    dbuf_uart_tx_fsm #(
        .OSR_NORMAL (OSR_NORMAL),
        .OSR_DOUBLE (OSR_DOUBLE),
        .WORD_W     (WORD_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (drive_q),
        .buf_valid  (buf_full_q),
        .buf_word   (buf_q),
        .cfg        (frame_q),
        .tick       (tick),
        .take       (take),
        .busy       (busy),
        .txd_bit    (txd_bit),
        .frame_done (frame_done)
    );

    assign txd         = drive_q ? txd_bit : 1'b1;
    assign line_active = drive_q;
    assign dre_flag    = !buf_full_q;
    assign txc_flag    = txc_q;
    assign dre_irq     = ctrl_q.dre_ie && irq_global_en && !buf_full_q;
    assign txc_irq     = ctrl_q.txc_ie && irq_global_en && txc_q;

    a_r1_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && buf_full_q && !take) |=> buf_full_q && $stable(buf_q));
    a_r3_take_empties_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !buf_full_q);
    a_r7_txc_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txc_q) |-> $past(frame_done && !buf_full_q));
    a_r8_release_when_drained: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_q) |-> $past(!buf_full_q && !busy && !ctrl_q.en));

endmodule

// File: tb/dbuf_uart_tx_tb.sv
module dbuf_uart_tx_tb;
    import dbuf_uart_tx_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       txc_ack = 1'b0;
    logic       irq_global_en = 1'b0;
    logic       txd, line_active, dre_flag, txc_flag, dre_irq, txc_irq;

    always #4 clk = ~clk;

    dbuf_uart_tx u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .txc_ack(txc_ack), .irq_global_en(irq_global_en),
        .txd(txd), .line_active(line_active), .dre_flag(dre_flag),
        .txc_flag(txc_flag), .dre_irq(dre_irq), .txc_irq(txc_irq)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    int cfg_n = 8, cfg_par = 0, cfg_stop = 1, cfg_per = 16;
    logic [8:0] rx_q[$];
    int rx_err = 0;

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'(addr); bus_wdata = 8'(data);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_cfg(input int code, input int n, input int par, input int stops, input int per);
        wr(ADDR_FRAME, code);
        cfg_n = n; cfg_par = par; cfg_stop = stops; cfg_per = per;
    endtask

    task automatic wait_frames(input int k);
        int g = 0;
        while (rx_q.size() < k && g < 20000) begin @(negedge clk); g++; end
        repeat (cfg_per + 4) @(negedge clk);
    endtask

    // line receiver model: samples each bit at its middle
    initial begin
        forever begin
            @(negedge clk);
            if (line_active && txd === 1'b0) begin
                logic [8:0] v;
                int ones;
                v = '0; ones = 0;
                repeat (cfg_per / 2) @(negedge clk);
                if (txd !== 1'b0) rx_err++;
                for (int i = 0; i < cfg_n; i++) begin
                    repeat (cfg_per) @(negedge clk);
                    v[i] = txd;
                    if (txd) ones++;
                end
                if (cfg_par != 0) begin
                    repeat (cfg_per) @(negedge clk);
                    if (txd !== ((ones % 2 == 1) ^ (cfg_par == 2))) rx_err++;
                end
                for (int s = 0; s < cfg_stop; s++) begin
                    repeat (cfg_per) @(negedge clk);
                    if (txd !== 1'b1) rx_err++;
                end
                rx_q.push_back(v);
            end
        end
    end

    task automatic t_reset;
        chk_eq("R2", "dre after reset", dre_flag, 1);
        chk_eq("R2", "txc after reset", txc_flag, 0);
        chk_eq("R2", "txd after reset", txd, 1);
        chk_eq("R2", "line_active after reset", line_active, 0);
        chk_eq("R2", "irqs after reset", {dre_irq, txc_irq}, 0);
    endtask

    task automatic t_basic;
        wr(ADDR_CTRL, 1);
        set_cfg(3, 8, 0, 1, 16);
        wr(ADDR_DATA, 8'hA5);
        @(negedge clk);
        chk_eq("R3", "start bit one clock after load", txd, 0);
        chk_eq("R3", "dre back to 1 after move", dre_flag, 1);
        wait_frames(1);
        chk_eq("R4", "8N1 frame data", rx_q.size() > 0 ? int'(rx_q[0]) : -1, 'hA5);
        chk_eq("R4", "8N1 framing errors", rx_err, 0);
        rx_q.delete(); rx_err = 0;
    endtask

    task automatic t_ignore;
        wr(ADDR_DATA, 8'h11);
        wr(ADDR_DATA, 8'h22);
        chk_eq("R1", "dre low with buffer held", dre_flag, 0);
        wr(ADDR_DATA, 8'h33);
        wait_frames(2);
        repeat (3 * 10 * cfg_per) @(negedge clk);
        chk_eq("R1", "frame count with dropped write", rx_q.size(), 2);
        chk_eq("R1", "first frame", rx_q.size() > 0 ? int'(rx_q[0]) : -1, 'h11);
        chk_eq("R1", "second frame kept, not overwritten", rx_q.size() > 1 ? int'(rx_q[1]) : -1, 'h22);
        rx_q.delete(); rx_err = 0;
    endtask

    task automatic start_len(input int exp, input string what);
        int cnt = 0, g = 0;
        wr(ADDR_DATA, 8'h01);
        while (txd !== 1'b0 && g < 100) begin @(negedge clk); g++; end
        while (txd === 1'b0 && cnt < 10000) begin cnt++; @(negedge clk); end
        chk_eq("R5", what, cnt, exp);
        wait_frames(1);
        chk_eq("R5", "data at this rate", rx_q.size() > 0 ? int'(rx_q[0]) : -1, 1);
        rx_q.delete();
    endtask

    task automatic t_period;
        wr(ADDR_DIV_LO, 2);
        set_cfg(3, 8, 0, 1, 48);
        start_len(48, "bit length divisor 2 normal");
        set_cfg('h43, 8, 0, 1, 24);
        start_len(24, "bit length divisor 2 double speed");
        wr(ADDR_DIV_LO, 0);
        set_cfg(3, 8, 0, 1, 16);
        chk_eq("R5", "errors at rate change", rx_err, 0);
        rx_err = 0;
    endtask

    task automatic frame_len(input int data, input int exp_len, input int exp_val, input string req);
        int cnt = 0, g = 0;
        wr(ADDR_FLAGS, 1);
        wr(ADDR_DATA, data);
        while (txd !== 1'b0 && g < 100) begin @(negedge clk); g++; end
        while (txc_flag !== 1'b1 && cnt < 5000) begin @(negedge clk); cnt++; end
        chk_eq(req, "frame length to txc", cnt, exp_len);
        wait_frames(1);
        chk_eq(req, "frame data", rx_q.size() > 0 ? int'(rx_q[0]) : -1, exp_val);
        chk_eq(req, "frame errors", rx_err, 0);
        rx_q.delete(); rx_err = 0;
    endtask

    task automatic t_formats;
        set_cfg('h30, 5, 1, 2, 16);
        frame_len('hFB, 9 * 16, 'h1B, "R6");
        set_cfg('h1A, 7, 2, 1, 16);
        frame_len('h55, 10 * 16, 'h55, "R4");
        wr(ADDR_CTRL, 3);
        set_cfg('h07, 9, 0, 1, 16);
        frame_len('hF0, 11 * 16, 'h1F0, "R4");
        wr(ADDR_CTRL, 1);
        set_cfg('h23, 8, 0, 2, 16);
        wr(ADDR_DATA, 'h81);
        wr(ADDR_DATA, 'h7E);
        wait_frames(2);
        chk_eq("R6", "back-to-back two-stop errors", rx_err, 0);
        chk_eq("R6", "second back-to-back frame", rx_q.size() > 1 ? int'(rx_q[1]) : -1, 'h7E);
        rx_q.delete(); rx_err = 0;
        set_cfg(3, 8, 0, 1, 16);
    endtask

    task automatic t_ninth;
        set_cfg(7, 9, 0, 1, 16);
        wr(ADDR_CTRL, 3);
        wr(ADDR_DATA, 'h3C);
        wr(ADDR_CTRL, 1);
        wr(ADDR_DATA, 'h3C);
        wait_frames(2);
        chk_eq("R9", "ninth bit latched with write", rx_q.size() > 0 ? int'(rx_q[0]) : -1, 'h13C);
        chk_eq("R9", "ninth bit clear on next write", rx_q.size() > 1 ? int'(rx_q[1]) : -1, 'h03C);
        rx_q.delete(); rx_err = 0;
        set_cfg(3, 8, 0, 1, 16);
    endtask

    task automatic t_txc;
        wr(ADDR_FLAGS, 1);
        wr(ADDR_DATA, 'h5A);
        wr(ADDR_DATA, 'hA5);
        begin
            int g = 0;
            while (rx_q.size() < 1 && g < 20000) begin @(negedge clk); g++; end
        end
        repeat (cfg_per) @(negedge clk);
        chk_eq("R7", "txc held low while next char waits", txc_flag, 0);
        wait_frames(2);
        chk_eq("R7", "txc after drain", txc_flag, 1);
        wr(ADDR_FLAGS, 0);
        chk_eq("R7", "write 0 keeps txc", txc_flag, 1);
        wr(ADDR_FLAGS, 1);
        chk_eq("R7", "write 1 clears txc", txc_flag, 0);
        rx_q.delete();
        wr(ADDR_DATA, 'h0F);
        wait_frames(1);
        chk_eq("R7", "txc set again", txc_flag, 1);
        @(negedge clk); txc_ack = 1'b1;
        @(negedge clk); txc_ack = 1'b0;
        chk_eq("R7", "ack clears txc", txc_flag, 0);
        rx_q.delete(); rx_err = 0;
    endtask

    task automatic t_disable;
        wr(ADDR_DATA, 'hC3);
        wr(ADDR_DATA, 'h3C);
        wr(ADDR_CTRL, 0);
        chk_eq("R8", "line still driven after disable", line_active, 1);
        wait_frames(2);
        chk_eq("R8", "queued chars sent", rx_q.size() > 1 ? int'(rx_q[1]) : -1, 'h3C);
        chk_eq("R8", "line released after drain", line_active, 0);
        chk_eq("R8", "txd idle after release", txd, 1);
        rx_q.delete();
        wr(ADDR_DATA, 'h99);
        repeat (300) @(negedge clk);
        chk_eq("R8", "char held while released", dre_flag, 0);
        chk_eq("R8", "nothing sent while released", rx_q.size(), 0);
        wr(ADDR_CTRL, 1);
        wait_frames(1);
        chk_eq("R8", "held char sent after enable", rx_q.size() > 0 ? int'(rx_q[0]) : -1, 'h99);
        rx_q.delete(); rx_err = 0;
    endtask

    task automatic t_irq;
        wr(ADDR_CTRL, 5);
        @(negedge clk); irq_global_en = 1'b1; #1;
        chk_eq("R10", "dre_irq all enables", dre_irq, 1);
        irq_global_en = 1'b0; #1;
        chk_eq("R10", "dre_irq global off", dre_irq, 0);
        wr(ADDR_CTRL, 9);
        @(negedge clk); irq_global_en = 1'b1; #1;
        chk_eq("R10", "dre_irq own enable off", dre_irq, 0);
        chk_eq("R10", "txc_irq with txc set", txc_irq, 1);
        wr(ADDR_FLAGS, 1);
        chk_eq("R10", "txc_irq after clear", txc_irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_ignore();
        t_period();
        t_formats();
        t_ninth();
        t_txc();
        t_disable();
        t_irq();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule